// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block drives a single shared bus on which address and data travel over the same lines, one after the other. An internal client hands it a request made of a direction, an access size and a 26-bit address. The master then runs one bus cycle. The cycle opens with a one-clock address phase, in which the address and a 3-bit size code sit together on the shared lines. One or more data beats follow, each held until the target pulls an active-low ready input low. The data width is a parameter and may be 32 or 64 bits.

A 32-byte line request becomes a single unbroken burst that covers the whole aligned line. The first beat carries the requested datum and the rest follow in ascending order, wrapping inside the line. Chip select stays low over the whole cycle. The frame signal rises as the final beat starts, so the target knows which beat ends the transfer. During data beats the master publishes the address of the current beat, so the client can supply write data for it. Read data comes back one beat at a time with a valid pulse, and a done pulse closes each request.

Top module: `mpx_bus_master`

## Requirements
- R1: One cycle after a request is accepted, the address phase is on the bus. `bus_cs_n`, `bus_bs_n` and `bus_frame_n` are low and `bus_dq_oe` is high. `bus_dq_o[25:0]` holds the request address, the top three bits hold the size code, and all other bits are zero.
- R2: `req_size` is encoded 0 = byte, 1 = word, 2 = longword, 3 = 32-byte line. The matching size codes on the bus are 000, 001, 010 and 100.
- R3: `bus_bs_n` is low for exactly one clock per request, and only in the address phase.
- R4: `bus_cs_n` stays low from the address phase until the cycle in which the final beat completes, and rises after that unless a new request is taken in that cycle. A request taken in that cycle starts its address phase on the next clock with `bus_cs_n` still low, with no idle cycle in between.
- R5: `bus_frame_n` is low in the address phase and in every data beat except the final one, and high in the final beat. A single-beat access has frame high in its only data beat.
- R6: A line request makes 32/(DATA_W/8) data beats: 8 on a 32-bit bus and 4 on a 64-bit bus. Byte, word and longword requests make one beat.
- R7: During a data beat, `beat_addr` is the beat's address. For a line request, beat k has address line_base + ((start_slot + k) mod beats) × (DATA_W/8), with the low bits zero. For any other size, it is the request address.
- R8: A data beat completes only on a rising edge at which `bus_rdy_n` is low. Until then the beat does not move on. For writes, `bus_dq_o` carries `wr_data` with `bus_dq_oe` high through every data beat.
- R9: For reads, `rd_valid` pulses on the cycle after each beat completes, and `rd_data` holds the `bus_dq_i` value sampled at that completion.
- R10: `done` pulses for one cycle on the cycle after the final beat of a request completes.
- R11: `req_ready` is high only while the bus is idle or during the final beat with `bus_rdy_n` low. It is low in the address phase and in every other data beat.
- R12: After reset the bus is idle: `bus_cs_n`, `bus_bs_n` and `bus_frame_n` are high, `bus_dq_oe` is low, `done` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client presents a request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 line |
| req_addr | input | 26 | Byte address |
| wr_data | input | DATA_W | Write datum for the beat at `beat_addr` |
| beat_addr | output | 26 | Address of the current data beat |
| rd_valid | output | 1 | One read beat delivered |
| rd_data | output | DATA_W | Read datum |
| done | output | 1 | Request finished |
| bus_dq_o | output | DATA_W | Shared lines, driven value |
| bus_dq_oe | output | 1 | Shared lines output enable |
| bus_dq_i | input | DATA_W | Shared lines, sampled value |
| bus_bs_n | output | 1 | Bus-start strobe, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_frame_n | output | 1 | Frame, active low |
| bus_rdy_n | input | 1 | Target ready, active low |

## Verification
The table of vectors covers every size and both directions. Each vector has its own number of wait states, from none to several, so the size-code lanes, the beat count and the hold under a high ready can each be told apart. Two line requests start at different slots, one in the middle of the line and one in the last slot. This separates a true wrap inside the line from a plain increment, or from restarting at slot zero. A directed back-to-back pair, with the second request taken during the final beat, shows whether chip select stays low and the next address phase follows with no gap.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
  localparam int ADDR_W     = 26;
  localparam int LINE_BYTES = 32;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_LINE = 2'd3} mpx_size_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ADDR = 2'd1, PH_DATA = 2'd2} mpx_phase_e;

  // 3-bit code carried on the top lanes during the address phase
  function automatic logic [2:0] size_code(input mpx_size_e s);
    case (s)
      SZ_BYTE: size_code = 3'b000;
      SZ_WORD: size_code = 3'b001;
      SZ_LONG: size_code = 3'b010;
      default: size_code = 3'b100;
    endcase
  endfunction
endpackage

// File: rtl/mpx_beat_seq.sv
module mpx_beat_seq
  import mpx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  mpx_size_e         size,
  input  logic [ADDR_W-1:0] base,
  output logic              last,
  output logic [ADDR_W-1:0] beat_addr
);
  localparam int BYTES = DATA_W / 8;
  localparam int NB    = LINE_BYTES / BYTES;
  localparam int CW    = $clog2(NB);
  localparam int SH    = $clog2(BYTES);
  localparam int LSH   = $clog2(LINE_BYTES);

  logic [CW-1:0] cnt;
  logic [CW-1:0] slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  // slot wraps naturally at CW bits, i.e. inside the aligned line
  assign slot = base[LSH-1:SH] + cnt;
  assign last = (size != SZ_LINE) || (cnt == CW'(NB - 1));

  always_comb begin
    if (size == SZ_LINE) beat_addr = {base[ADDR_W-1:LSH], slot, {SH{1'b0}}};
    else                 beat_addr = base;
  end
endmodule

// File: rtl/mpx_phase_fsm.sv
module mpx_phase_fsm
  import mpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  mpx_size_e         req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rdy_n,
  input  logic              last,
  output mpx_phase_e        phase,
  output logic              accept,
  output logic              beat_done,
  output logic              last_xfer,
  output logic              req_ready,
  output logic              cur_write,
  output mpx_size_e         cur_size,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              done
);
  mpx_phase_e nxt;

  assign beat_done = (phase == PH_DATA) && !rdy_n;
  assign last_xfer = beat_done && last;
  assign req_ready = (phase == PH_IDLE) || last_xfer;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE: if (accept) nxt = PH_ADDR;
      PH_ADDR: nxt = PH_DATA;
      PH_DATA: if (last_xfer) nxt = accept ? PH_ADDR : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur_write <= 1'b0;
      cur_size  <= SZ_BYTE;
      cur_addr  <= '0;
      done      <= 1'b0;
    end else begin
      phase <= nxt;
      done  <= last_xfer;
      if (accept) begin
        cur_write <= req_write;
        cur_size  <= req_size;
        cur_addr  <= req_addr;
      end
    end
  end
endmodule

// File: rtl/mpx_lane_drv.sv
module mpx_lane_drv
  import mpx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  mpx_phase_e        phase,
  input  logic              cur_write,
  input  mpx_size_e         cur_size,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              last,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              bs_n,
  output logic              cs_n,
  output logic              frame_n
);
  localparam int GAP = DATA_W - 3 - ADDR_W;
  logic [DATA_W-1:0] addr_word;

  generate
    if (GAP > 0) begin : g_gap
      assign addr_word = {size_code(cur_size), {GAP{1'b0}}, cur_addr};
    end else begin : g_nogap
      assign addr_word = {size_code(cur_size), cur_addr[DATA_W-4:0]};
    end
  endgenerate

  always_comb begin
    cs_n    = (phase == PH_IDLE);
    bs_n    = (phase != PH_ADDR);
    frame_n = !((phase == PH_ADDR) || ((phase == PH_DATA) && !last));
    dq_oe   = (phase == PH_ADDR) || ((phase == PH_DATA) && cur_write);
    dq_o    = (phase == PH_ADDR) ? addr_word : (dq_oe ? wr_data : '0);
  end
endmodule

// File: rtl/mpx_bus_master.sv
module mpx_bus_master
  import mpx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [25:0]       req_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [25:0]       beat_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_i,
  output logic              bus_bs_n,
  output logic              bus_cs_n,
  output logic              bus_frame_n,
  input  logic              bus_rdy_n
);
  mpx_phase_e        phase;
  logic              accept, beat_done, last_xfer, last;
  logic              cur_write;
  mpx_size_e         cur_size;
  logic [ADDR_W-1:0] cur_addr;

  mpx_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(mpx_size_e'(req_size)), .req_addr(req_addr), .rdy_n(bus_rdy_n),
    .last(last), .phase(phase), .accept(accept), .beat_done(beat_done),
    .last_xfer(last_xfer), .req_ready(req_ready), .cur_write(cur_write),
    .cur_size(cur_size), .cur_addr(cur_addr), .done(done)
  );

  mpx_beat_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .step(beat_done && !last),
    .size(cur_size), .base(cur_addr), .last(last), .beat_addr(beat_addr)
  );

  mpx_lane_drv #(.DATA_W(DATA_W)) u_drv (
    .phase(phase), .cur_write(cur_write), .cur_size(cur_size), .cur_addr(cur_addr),
    .last(last), .wr_data(wr_data), .dq_o(bus_dq_o), .dq_oe(bus_dq_oe),
    .bs_n(bus_bs_n), .cs_n(bus_cs_n), .frame_n(bus_frame_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= beat_done && !cur_write;
      if (beat_done && !cur_write) rd_data <= bus_dq_i;
    end
  end
endmodule

// File: rtl/mpx_bus_master_chk.sv
module mpx_bus_master_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_bs_n,
  input logic bus_cs_n,
  input logic bus_frame_n,
  input logic bus_dq_oe,
  input logic last_xfer,
  input logic done,
  input logic req_ready
);
  p_bs_single_r3: assert property (@(posedge clk) disable iff (!rst_n) !bus_bs_n |=> bus_bs_n);
  p_bs_in_cs_r3:  assert property (@(posedge clk) disable iff (!rst_n) !bus_bs_n |-> !bus_cs_n);
  p_addr_oe_r1:   assert property (@(posedge clk) disable iff (!rst_n) !bus_bs_n |-> (bus_dq_oe && !bus_frame_n));
  p_frame_cs_r5:  assert property (@(posedge clk) disable iff (!rst_n) !bus_frame_n |-> !bus_cs_n);
  p_cs_hold_r4:   assert property (@(posedge clk) disable iff (!rst_n) (!bus_cs_n && !last_xfer) |=> !bus_cs_n);
  p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n) (!bus_cs_n && !last_xfer) |-> !req_ready);
  p_done_last_r10: assert property (@(posedge clk) disable iff (!rst_n) last_xfer |=> done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) done |-> !last_xfer || bus_cs_n == 1'b0);
endmodule

bind mpx_bus_master mpx_bus_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_bs_n(bus_bs_n), .bus_cs_n(bus_cs_n),
  .bus_frame_n(bus_frame_n), .bus_dq_oe(bus_dq_oe), .last_xfer(last_xfer),
  .done(done), .req_ready(req_ready)
);

// File: tb/sim_mpx_bus_master.sv
`timescale 1ns/1ps
module sim_mpx_bus_master;
  localparam int DW = 32;
  localparam int BYTES = DW / 8;
  localparam int NB = 32 / BYTES;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, bus_rdy_n = 1'b1;
  logic [1:0] req_size = 2'd0;
  logic [25:0] req_addr = '0;
  logic [DW-1:0] wr_data, bus_dq_i, rd_data, bus_dq_o;
  logic [25:0] beat_addr;
  logic req_ready, rd_valid, done, bus_dq_oe, bus_bs_n, bus_cs_n, bus_frame_n;

  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] wpat(input logic [25:0] a);
    return DW'(a) ^ DW'(32'hC3C3_C3C3);
  endfunction
  function automatic logic [DW-1:0] rpat(input logic [25:0] a);
    return DW'(a) * DW'(3) + DW'(32'h0700_0007);
  endfunction

  assign wr_data  = wpat(beat_addr);
  assign bus_dq_i = rpat(beat_addr);

  mpx_bus_master #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .wr_data(wr_data), .beat_addr(beat_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i),
    .bus_bs_n(bus_bs_n), .bus_cs_n(bus_cs_n), .bus_frame_n(bus_frame_n),
    .bus_rdy_n(bus_rdy_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 encoding, written as a lookup rather than a shift
  function automatic logic [2:0] exp_code(input logic [1:0] s);
    if (s == 2'd3) return 3'b100;
    return {1'b0, s};
  endfunction

  // R7 beat address
  function automatic logic [25:0] exp_beat(input logic [25:0] a, input logic [1:0] s, input int k);
    int slot;
    if (s != 2'd3) return a;
    slot = ((int'(a) % 32) / BYTES + k) % NB;
    return 26'((int'(a) / 32) * 32 + slot * BYTES);
  endfunction

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [25:0] addr;
    logic [3:0]  waits;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 2'd0, 26'h0123457, 4'd0},
    '{1'b1, 2'd1, 26'h2000002, 4'd1},
    '{1'b0, 2'd2, 26'h3ABCDE4, 4'd2},
    '{1'b0, 2'd3, 26'h010000C, 4'd0},
    '{1'b1, 2'd3, 26'h3FFFFFC, 4'd1},
    '{1'b1, 2'd0, 26'h0000031, 4'd3},
    '{1'b1, 2'd2, 26'h1555554, 4'd0}
  };

  // Sampling at negedge; request already set up by caller when chain==0.
  task automatic data_beats(input logic wr, input logic [1:0] sz, input logic [25:0] a,
                            input int waits);
    int nbeats;
    nbeats = (sz == 2'd3) ? NB : 1;   // R6
    for (int k = 0; k < nbeats; k++) begin
      for (int w = 0; w <= waits; w++) begin
        chk("R7 beat_addr", beat_addr, exp_beat(a, sz, k));
        chk("R5 frame_n", bus_frame_n, (k == nbeats - 1));
        chk("R3 bs_n data", bus_bs_n, 1'b1);
        chk("R4 cs_n data", bus_cs_n, 1'b0);
        chk("R8 dq_oe", bus_dq_oe, wr);
        if (wr) chk("R8 dq_o write", bus_dq_o, wpat(exp_beat(a, sz, k)));
        bus_rdy_n = (w == waits) ? 1'b0 : 1'b1;
        #1;
        chk("R11 req_ready", req_ready, (w == waits) && (k == nbeats - 1));
        @(posedge clk); @(negedge clk);
        bus_rdy_n = 1'b1;
        if (w != waits) chk("R8 held rd_valid", rd_valid, 1'b0);
      end
      chk("R9 rd_valid", rd_valid, !wr);
      if (!wr) chk("R9 rd_data", rd_data, rpat(exp_beat(a, sz, k)));
      chk("R10 done", done, (k == nbeats - 1));
    end
  endtask

  task automatic run_xfer(input logic wr, input logic [1:0] sz, input logic [25:0] a,
                          input int waits);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
    #1;
    chk("R11 idle ready", req_ready, 1'b1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R1 cs_n", bus_cs_n, 1'b0);
    chk("R3 bs_n", bus_bs_n, 1'b0);
    chk("R1 frame_n", bus_frame_n, 1'b0);
    chk("R1 dq_oe", bus_dq_oe, 1'b1);
    chk("R2 addr word", bus_dq_o, {exp_code(sz), {(DW - 29){1'b0}}, a});
    @(posedge clk); @(negedge clk);
    data_beats(wr, sz, a, waits);
    chk("R4 cs_n released", bus_cs_n, 1'b1);
  endtask

  initial begin
    #(100000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 cs_n", bus_cs_n, 1'b1);
    chk("R12 bs_n", bus_bs_n, 1'b1);
    chk("R12 frame_n", bus_frame_n, 1'b1);
    chk("R12 dq_oe", bus_dq_oe, 1'b0);
    chk("R12 done", done, 1'b0);
    chk("R12 rd_valid", rd_valid, 1'b0);
    chk("R12 req_ready", req_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      run_xfer(VECS[i].wr, VECS[i].sz, VECS[i].addr, int'(VECS[i].waits));
      @(negedge clk);
    end

    // Directed: back-to-back at minimum pitch (R4, R10, R11)
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd3; req_addr = 26'h0200018;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < NB - 1; k++) begin
      bus_rdy_n = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    bus_rdy_n = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd1; req_addr = 26'h0ABCDE6;
    #1;
    chk("R11 ready on final beat", req_ready, 1'b1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; bus_rdy_n = 1'b1;
    chk("R4 cs_n no gap", bus_cs_n, 1'b0);
    chk("R3 bs_n next addr", bus_bs_n, 1'b0);
    chk("R10 done first", done, 1'b1);
    chk("R9 last read beat", rd_data, rpat(exp_beat(26'h0200018, 2'd3, NB - 1)));
    chk("R2 addr word next", bus_dq_o, {3'b001, {(DW - 29){1'b0}}, 26'h0ABCDE6});
    @(posedge clk); @(negedge clk);
    data_beats(1'b1, 2'd1, 26'h0ABCDE6, 2);
    chk("R4 cs_n end", bus_cs_n, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule